// File: doc/BRIEF.md
# Serial Command Front-End for a Byte-Wide Memory

This block is the command side of a small byte-wide memory that is always the target of an SPI bus. It never makes a clock. It watches chip select, serial clock, serial input, a pause input and a write-guard input. Each serial pin is sampled on the system clock. The first byte after chip select falls is decoded as a command. The block then collects the address and data bytes, or it streams memory or status bytes back on a serial output that has its own drive enable. The memory behind it is a 512 x 8 array model with a timed write cycle. While that cycle runs, the block reports busy.

Writes are gathered into a page buffer and committed when chip select rises. The commit happens only if every data byte arrived whole, a write-enable latch was set, and the write guard stayed high. An unknown command locks the link until the next chip-select falling edge. The pause input freezes a transfer mid-byte without losing its place.

The serial pins are plain control inputs. No data stream leaves the block through a handshake, so the block applies no back-pressure. The host controls pacing with the serial clock and with the pause input.

Top module: `spi_mem_front`

## Requirements
- R1: The block captures serial input on each rising edge of `sck`, most significant bit first. `so` changes only after a falling edge of `sck`, and output bytes also go out most significant bit first.
- R2: While `cs_n` is high, edges on `sck` and `si` have no effect and `so_oe` is 0. Each falling edge of `cs_n` restarts the bit and byte sequence at the command byte.
- R3: The command byte selects the operation. 0x06 sets the write-enable latch and 0x04 clears it. 0x05 returns the status byte `{6'b0, wel, busy}` over and over. 0x01 takes one data byte and has no effect. 0x03 or 0x0B is a read and 0x02 or 0x0A is a write; in both, command bit 3 is address bit 8 and the next byte supplies address bits 7..0.
- R4: After any other command byte, further input has no effect and `so_oe` stays 0 until the next falling edge of `cs_n`.
- R5: A read streams bytes starting at the given address and adds one to the address after each byte. The address wraps from 0x1FF to 0x000.
- R6: Write data goes into an 8-byte page, and the page is the address with bits 2..0 cleared. Bytes past the end of the page wrap to the start of the same page. The write commits at the rising edge of `cs_n` only if at least one byte arrived and the bit count is a multiple of eight.
- R7: A write commits only while the write-enable latch is set. The latch clears when the internal write cycle ends.
- R8: A write does not commit if `wp_n` is low at the rising edge of `cs_n`, or if `wp_n` was low at any time during the address or data phase. After the write cycle has started, `wp_n` has no effect on it.
- R9: From a commit, busy (status bit 0) stays set for `TWR_CYCLES` system clocks.
- R10: While busy is set, any command other than 0x05 locks the link as in R4.
- R11: A pause starts only when `hold_n` is low while `sck` is low. It ends only when `hold_n` is high while `sck` is low. During a pause, `sck` edges and `si` are ignored and `so_oe` is 0. The transfer then resumes at the same bit.
- R12: After reset, `so_oe` is 0, busy and the write-enable latch are clear, and every memory byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample all serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the bus controller |
| si | input | 1 | Serial data into the block |
| hold_n | input | 1 | Pause request, active low |
| wp_n | input | 1 | Write guard, active low |
| so | output | 1 | Serial data out of the block |
| so_oe | output | 1 | Drive enable for `so`; 0 means high impedance |

## Verification
The assertions assume that `sck` is low whenever `cs_n` changes. They also assume that each level of `sck`, `si` and `hold_n` lasts several system clocks, so that every bus edge appears as one clean edge after sampling. The assertions that follow a commit assume that no second write is requested while busy is set. The bench holds every `sck` phase for three system clocks and changes `si` only while `sck` is low. It lowers `sck` before it moves `cs_n`, and it changes `hold_n` only with `sck` low. It also waits out each write cycle before it sends the next write.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  localparam int ADDR_W = 9;

  typedef enum logic [2:0] {
    OP_WREN, OP_WRDI, OP_RDSR, OP_WRSR, OP_READ, OP_WRITE, OP_BAD
  } op_kind_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_WDATA, ST_RDATA, ST_STAT, ST_SKIP, ST_LOCK
  } eng_st_t;

  function automatic op_kind_t decode_op(input logic [7:0] b);
    if (b == 8'h06) return OP_WREN;
    if (b == 8'h04) return OP_WRDI;
    if (b == 8'h05) return OP_RDSR;
    if (b == 8'h01) return OP_WRSR;
    if ((b & 8'hF7) == 8'h03) return OP_READ;
    if ((b & 8'hF7) == 8'h02) return OP_WRITE;
    return OP_BAD;
  endfunction

endpackage

// File: rtl/spi_link_ctl.sv
module spi_link_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic hold_n,
  output logic sel_o,
  output logic cs_fall_o,
  output logic cs_rise_o,
  output logic rise_o,
  output logic fall_o,
  output logic held_o
);

  logic cs_q, sck_q, held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      sck_q  <= 1'b0;
      held_q <= 1'b0;
    end else begin
      cs_q  <= cs_n;
      sck_q <= sck;
      if (cs_n)
        held_q <= 1'b0;
      else if (!held_q && !hold_n && !sck)
        held_q <= 1'b1;
      else if (held_q && hold_n && !sck)
        held_q <= 1'b0;
    end
  end

  assign sel_o     = !cs_n;
  assign cs_fall_o = !cs_n && cs_q;
  assign cs_rise_o = cs_n && !cs_q;
  assign rise_o    = sck && !sck_q && !cs_n && !held_q;
  assign fall_o    = !sck && sck_q && !cs_n && !held_q;
  assign held_o    = held_q;

  // R11
  hold_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held_q) |-> !$past(sck));

  // R11
  hold_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(held_q) && !$past(cs_n) |-> !$past(sck) && $past(hold_n));

endmodule

// File: rtl/spi_mem_store.sv
module spi_mem_store
  import spi_mem_pkg::*;
#(
  parameter int PAGE_BYTES = 8,
  parameter int TWR_CYCLES = 300
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              commit_i,
  input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page_i,
  input  logic [PAGE_BYTES-1:0]             mask_i,
  input  logic [PAGE_BYTES*8-1:0]           data_i,
  input  logic [ADDR_W-1:0]                 rd_addr_i,
  output logic [7:0]                        rd_data_o,
  output logic                              busy_o,
  output logic                              wr_done_o
);

  localparam int DEPTH   = 1 << ADDR_W;
  localparam int PAGE_AW = $clog2(PAGE_BYTES);
  localparam int CNT_W   = $clog2(TWR_CYCLES + 1);

  logic [7:0]       mem [DEPTH];
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= 8'hFF;
    end else if (commit_i && !busy_o) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (mask_i[i]) mem[{page_i, PAGE_AW'(i)}] <= data_i[i*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (commit_i && !busy_o)
      cnt <= CNT_W'(TWR_CYCLES);
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign busy_o    = (cnt != '0);
  assign wr_done_o = (cnt == CNT_W'(1));
  assign rd_data_o = mem[rd_addr_i];

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(commit_i));

  // R10
  no_commit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |-> !busy_o);

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_mem_pkg::*;
#(
  parameter int PAGE_BYTES = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              sel_i,
  input  logic                              cs_fall_i,
  input  logic                              cs_rise_i,
  input  logic                              rise_i,
  input  logic                              fall_i,
  input  logic                              held_i,
  input  logic                              si_i,
  input  logic                              wp_n_i,
  input  logic                              busy_i,
  input  logic                              wr_done_i,
  input  logic [7:0]                        rd_data_i,
  output logic [ADDR_W-1:0]                 rd_addr_o,
  output logic                              commit_o,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] commit_page_o,
  output logic [PAGE_BYTES-1:0]             commit_mask_o,
  output logic [PAGE_BYTES*8-1:0]           commit_data_o,
  output logic                              so_o,
  output logic                              so_oe_o
);

  localparam int PAGE_AW = $clog2(PAGE_BYTES);
  localparam int PG_W    = ADDR_W - PAGE_AW;

  eng_st_t             st;
  logic [2:0]          bit_cnt, ocnt;
  logic [6:0]          shreg;
  logic [7:0]          byte_now, cur_out, status;
  logic                byte_done, is_rd, a_hi, wel, wp_hit, drv, so_q;
  logic [PG_W-1:0]     wr_page;
  logic [PAGE_AW-1:0]  wr_off;
  logic [PAGE_BYTES-1:0] vld;
  logic [7:0]          pbuf [PAGE_BYTES];
  logic [ADDR_W-1:0]   rd_addr;
  op_kind_t            op_now;

  assign byte_now  = {shreg, si_i};
  assign byte_done = rise_i && (bit_cnt == 3'd7) && (st != ST_LOCK) && (st != ST_IDLE);
  assign op_now    = decode_op(byte_now);
  assign status    = {6'b0, wel, busy_i};
  assign cur_out   = (st == ST_RDATA) ? rd_data_i : status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      bit_cnt <= '0;
      ocnt    <= '0;
      shreg   <= '0;
      is_rd   <= 1'b0;
      a_hi    <= 1'b0;
      wp_hit  <= 1'b0;
      drv     <= 1'b0;
      so_q    <= 1'b0;
      wr_page <= '0;
      wr_off  <= '0;
      vld     <= '0;
      rd_addr <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= '0;
    end else if (cs_fall_i) begin
      st      <= ST_OPC;
      bit_cnt <= '0;
      ocnt    <= '0;
      vld     <= '0;
      wp_hit  <= 1'b0;
      drv     <= 1'b0;
    end else if (cs_rise_i) begin
      st  <= ST_IDLE;
      drv <= 1'b0;
    end else begin
      if (sel_i && !wp_n_i && !is_rd && (st == ST_ADDR || st == ST_WDATA))
        wp_hit <= 1'b1;
      if (rise_i && st != ST_LOCK && st != ST_IDLE) begin
        bit_cnt <= bit_cnt + 1'b1;
        shreg   <= byte_now[6:0];
      end
      if (byte_done) begin
        case (st)
          ST_OPC: begin
            case (op_now)
              OP_RDSR: begin st <= ST_STAT; ocnt <= '0; end
              OP_WREN, OP_WRDI, OP_WRSR: st <= busy_i ? ST_LOCK : ST_SKIP;
              OP_READ, OP_WRITE: begin
                st    <= busy_i ? ST_LOCK : ST_ADDR;
                is_rd <= (op_now == OP_READ);
                a_hi  <= byte_now[3];
              end
              default: st <= ST_LOCK;
            endcase
          end
          ST_ADDR: begin
            if (is_rd) begin
              rd_addr <= {a_hi, byte_now};
              ocnt    <= '0;
              st      <= ST_RDATA;
            end else begin
              wr_page <= {a_hi, byte_now[7:PAGE_AW]};
              wr_off  <= byte_now[PAGE_AW-1:0];
              st      <= ST_WDATA;
            end
          end
          ST_WDATA: begin
            pbuf[wr_off] <= byte_now;
            vld[wr_off]  <= 1'b1;
            wr_off       <= wr_off + 1'b1;
          end
          default: ;
        endcase
      end
      if (fall_i && (st == ST_RDATA || st == ST_STAT)) begin
        so_q <= cur_out[3'd7 - ocnt];
        ocnt <= ocnt + 1'b1;
        drv  <= 1'b1;
        if (st == ST_RDATA && ocnt == 3'd7) rd_addr <= rd_addr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wel <= 1'b0;
    else if (wr_done_i)
      wel <= 1'b0;
    else if (byte_done && st == ST_OPC && !busy_i) begin
      if (op_now == OP_WREN) wel <= 1'b1;
      else if (op_now == OP_WRDI) wel <= 1'b0;
    end
  end

  assign commit_o = cs_rise_i && (st == ST_WDATA) && (bit_cnt == 3'd0) && (|vld)
                    && wel && wp_n_i && !wp_hit && !busy_i;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_flat
    assign commit_data_o[g*8 +: 8] = pbuf[g];
  end

  assign commit_page_o = wr_page;
  assign commit_mask_o = vld;
  assign rd_addr_o     = rd_addr;
  assign so_o          = so_q;
  assign so_oe_o       = drv && sel_i && !held_i;

  // R4
  lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOCK) |-> !so_oe_o);

  // R1
  so_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(so_o) |-> $past(fall_i));

  // R2
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |-> !so_oe_o);

endmodule

// File: rtl/spi_mem_front.sv
module spi_mem_front
  import spi_mem_pkg::*;
#(
  parameter int PAGE_BYTES = 8,
  parameter int TWR_CYCLES = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic so,
  output logic so_oe
);

  localparam int PG_W = ADDR_W - $clog2(PAGE_BYTES);

  logic sel, cs_fall, cs_rise, rise, fall, held;
  logic busy, wr_done, commit;
  logic [7:0]              rd_data;
  logic [ADDR_W-1:0]       rd_addr;
  logic [PG_W-1:0]         commit_page;
  logic [PAGE_BYTES-1:0]   commit_mask;
  logic [PAGE_BYTES*8-1:0] commit_data;

  spi_link_ctl link_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
    .sel_o(sel), .cs_fall_o(cs_fall), .cs_rise_o(cs_rise),
    .rise_o(rise), .fall_o(fall), .held_o(held)
  );

  spi_cmd_engine #(.PAGE_BYTES(PAGE_BYTES)) eng_i (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
    .rise_i(rise), .fall_i(fall), .held_i(held), .si_i(si), .wp_n_i(wp_n),
    .busy_i(busy), .wr_done_i(wr_done), .rd_data_i(rd_data), .rd_addr_o(rd_addr),
    .commit_o(commit), .commit_page_o(commit_page), .commit_mask_o(commit_mask),
    .commit_data_o(commit_data), .so_o(so), .so_oe_o(so_oe)
  );

  spi_mem_store #(.PAGE_BYTES(PAGE_BYTES), .TWR_CYCLES(TWR_CYCLES)) store_i (
    .clk(clk), .rst_n(rst_n), .commit_i(commit), .page_i(commit_page),
    .mask_i(commit_mask), .data_i(commit_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .busy_o(busy), .wr_done_o(wr_done)
  );

endmodule

// File: tb/spi_mem_front_tb.sv
module spi_mem_front_tb_top;

  localparam int TWR = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
  logic so, so_oe;
  int   n_vec = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  spi_mem_front #(.PAGE_BYTES(8), .TWR_CYCLES(TWR)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_oe(so_oe)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_begin;
    sck = 1'b0; wait_clk(2); cs_n = 1'b0; wait_clk(2);
  endtask

  task automatic cs_end;
    sck = 1'b0; wait_clk(3); cs_n = 1'b1; wait_clk(3);
  endtask

  task automatic spi_bit(input logic b, output logic r, output logic oe);
    sck = 1'b0; si = b; wait_clk(3);
    sck = 1'b1; wait_clk(3);
    r = so; oe = so_oe;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx,
                      output logic oe_all, output logic oe_any);
    logic r, oe;
    oe_all = 1'b1; oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      spi_bit(tx[i], r, oe);
      rx[i] = r; oe_all &= oe; oe_any |= oe;
    end
  endtask

  task automatic cmd_op(input logic [7:0] op);
    logic [7:0] rx; logic a, b;
    cs_begin; xfer(op, rx, a, b); cs_end;
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] rx; logic a, b;
    cs_begin; xfer(8'h05, rx, a, b); xfer(8'h00, s, a, b); cs_end;
  endtask

  task automatic mem_write(input logic [8:0] adr, input logic [7:0] d0, d1, d2, input int n);
    logic [7:0] rx; logic a, b;
    cs_begin;
    xfer(adr[8] ? 8'h0A : 8'h02, rx, a, b);
    xfer(adr[7:0], rx, a, b);
    xfer(d0, rx, a, b);
    if (n > 1) xfer(d1, rx, a, b);
    if (n > 2) xfer(d2, rx, a, b);
    cs_end;
  endtask

  task automatic mem_read(input logic [8:0] adr, output logic [7:0] r0, r1, r2,
                          output logic oe_ok);
    logic [7:0] rx; logic a, b, c;
    cs_begin;
    xfer(adr[8] ? 8'h0B : 8'h03, rx, a, b);
    xfer(adr[7:0], rx, a, b);
    xfer(8'h00, r0, a, b);
    xfer(8'h00, r1, c, b); a &= c;
    xfer(8'h00, r2, c, b); a &= c;
    oe_ok = a;
    cs_end;
  endtask

  task automatic t_reset;
    logic [7:0] s, r0, r1, r2; logic ok;
    chk("R12 so_oe after reset", so_oe, 1'b0);
    rdsr(s);
    chk("R12 status after reset", s, 8'h00);
    mem_read(9'h005, r0, r1, r2, ok);
    chk("R12 erased byte", r0, 8'hFF);
    chk("R1 so_oe during read", ok, 1'b1);
  endtask

  task automatic t_deselected;
    logic [7:0] s; logic bad_oe = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; si = 8'h06 >> i; wait_clk(3);
      sck = 1'b1; wait_clk(3); bad_oe |= so_oe;
    end
    sck = 1'b0; wait_clk(3);
    chk("R2 so_oe with cs_n high", bad_oe, 1'b0);
    rdsr(s);
    chk("R2 ignored command while deselected", s, 8'h00);
  endtask

  task automatic t_write_read;
    logic [7:0] s, r0, r1, r2, rx; logic ok, a, any;
    cmd_op(8'h06);
    rdsr(s);
    chk("R3 enable latch set", s, 8'h02);
    mem_write(9'h110, 8'hAA, 8'h55, 8'h3C, 3);
    rdsr(s);
    chk("R9 busy after commit", s, 8'h03);
    cs_begin;
    xfer(8'h03, rx, a, any); xfer(8'h10, rx, a, any); xfer(8'h00, rx, a, any);
    cs_end;
    chk("R10 read during busy locks", any, 1'b0);
    wait_clk(TWR + 20);
    rdsr(s);
    chk("R7 enable latch cleared after cycle", s, 8'h00);
    mem_read(9'h110, r0, r1, r2, ok);
    chk("R5 byte 0", r0, 8'hAA);
    chk("R5 byte 1", r1, 8'h55);
    chk("R5 byte 2", r2, 8'h3C);
    mem_read(9'h010, r0, r1, r2, ok);
    chk("R3 A8 selects upper half", r0, 8'hFF);
  endtask

  task automatic t_wrap;
    logic [7:0] r0, r1, r2; logic ok;
    cmd_op(8'h06);
    mem_write(9'h1FE, 8'h21, 8'h22, 8'h23, 3);
    wait_clk(TWR + 20);
    cmd_op(8'h06);
    mem_write(9'h000, 8'h11, 8'h00, 8'h00, 1);
    wait_clk(TWR + 20);
    mem_read(9'h1FE, r0, r1, r2, ok);
    chk("R5 read at 0x1FE", r0, 8'h21);
    chk("R5 read at 0x1FF", r1, 8'h22);
    chk("R5 read wraps to 0x000", r2, 8'h11);
    mem_read(9'h1F8, r0, r1, r2, ok);
    chk("R6 page wrap to 0x1F8", r0, 8'h23);
  endtask

  task automatic t_partial_and_wel;
    logic [7:0] s, r0, r1, r2, rx; logic ok, a, b, r;
    cmd_op(8'h06);
    cs_begin;
    xfer(8'h02, rx, a, b); xfer(8'h30, rx, a, b); xfer(8'h44, rx, a, b);
    spi_bit(1'b1, r, a); spi_bit(1'b0, r, a); spi_bit(1'b1, r, a);
    cs_end;
    rdsr(s);
    chk("R6 partial byte no commit", s, 8'h02);
    mem_read(9'h030, r0, r1, r2, ok);
    chk("R6 partial byte memory unchanged", r0, 8'hFF);
    cmd_op(8'h04);
    rdsr(s);
    chk("R3 disable clears latch", s, 8'h00);
    mem_write(9'h020, 8'h99, 8'h00, 8'h00, 1);
    rdsr(s);
    chk("R7 no busy without enable", s, 8'h00);
    mem_read(9'h020, r0, r1, r2, ok);
    chk("R7 memory unchanged without enable", r0, 8'hFF);
  endtask

  task automatic t_guard;
    logic [7:0] r0, r1, r2, rx; logic ok, a, b;
    cmd_op(8'h06);
    cs_begin;
    xfer(8'h02, rx, a, b); xfer(8'h40, rx, a, b); xfer(8'h12, rx, a, b);
    wp_n = 1'b0; wait_clk(2); wp_n = 1'b1;
    cs_end;
    mem_read(9'h040, r0, r1, r2, ok);
    chk("R8 guard pulse cancels write", r0, 8'hFF);
    wp_n = 1'b0;
    mem_write(9'h040, 8'h56, 8'h00, 8'h00, 1);
    wp_n = 1'b1;
    mem_read(9'h040, r0, r1, r2, ok);
    chk("R8 guard low at cs rise cancels", r0, 8'hFF);
    mem_write(9'h040, 8'h34, 8'h00, 8'h00, 1);
    wp_n = 1'b0; wait_clk(TWR + 20); wp_n = 1'b1;
    mem_read(9'h040, r0, r1, r2, ok);
    chk("R8 guard after start has no effect", r0, 8'h34);
  endtask

  task automatic t_invalid;
    logic [7:0] s, rx; logic a, any, any2;
    cs_begin;
    xfer(8'hFF, rx, a, any);
    xfer(8'h06, rx, a, any);
    xfer(8'h05, rx, a, any2);
    cs_end;
    chk("R4 so_oe stays low after bad command", any | any2, 1'b0);
    rdsr(s);
    chk("R4 bytes after bad command ignored", s, 8'h00);
  endtask

  task automatic t_hold;
    logic [7:0] rx, d0, d1; logic a, b, r, oe, oe_h;
    cs_begin;
    xfer(8'h0B, rx, a, b); xfer(8'h10, rx, a, b);
    for (int i = 7; i >= 5; i--) begin spi_bit(1'b0, r, oe); d0[i] = r; end
    sck = 1'b0; wait_clk(3);
    hold_n = 1'b0; wait_clk(3);
    sck = 1'b1; si = 1'b1; wait_clk(3); oe_h = so_oe;
    sck = 1'b0; wait_clk(3);
    sck = 1'b1; wait_clk(3); oe_h |= so_oe;
    sck = 1'b0; wait_clk(3);
    chk("R11 so_oe low during pause", oe_h, 1'b0);
    hold_n = 1'b1; wait_clk(3);
    for (int i = 4; i >= 0; i--) begin spi_bit(1'b0, r, oe); d0[i] = r; end
    xfer(8'h00, d1, a, b);
    cs_end;
    chk("R11 byte across pause", d0, 8'hAA);
    chk("R11 next byte after pause", d1, 8'h55);
  endtask

  initial begin
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    t_reset;
    t_deselected;
    t_write_read;
    t_wrap;
    t_partial_and_wel;
    t_guard;
    t_invalid;
    t_hold;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule